// File: doc/BRIEF.md
# Block Translation Register Encoder

This block turns a requested address mapping into the two words that a block-translation register pair holds. A request carries a virtual base, a physical base, a region size, a supervisor-valid bit, a user-valid bit, two protection bits and a slot index. The block checks the size and builds a length mask that holds one set bit for each doubling of the size above 128 KB. It clears the low address bits of both bases below the region size. Then it packs an upper word and a lower word and writes the pair into the slot chosen by the index, in the instruction-side bank and the data-side bank at once.

Software or a boot sequencer drives one request per cycle. A request with an unusable size is refused with a one-cycle error pulse and leaves every slot unchanged. Any slot of either bank can be read back through a registered read port, which behaves like a block RAM that returns the old contents on a read that meets a write.

Top module: `blk_xlat_encoder`

## Requirements
- R1: For an accepted request of size 2^(17+k) bytes, upper word bits [12:2] hold a length mask with its k lowest bits set and all others clear. So 128 KB gives 0, 256 KB gives 1, 512 KB gives 3 and 256 MB gives 0x7FF.
- R2: Upper word bits [31:17+k] equal the same bits of the virtual base. Bits [16+k:13] are zero. Bit 1 is the supervisor-valid input and bit 0 is the user-valid input.
- R3: Lower word bits [31:17+k] equal the same bits of the physical base. Bits [1:0] are the protection input and all other bits are zero, including the cache-mode bits [6:3].
- R4: An accepted request writes the identical word pair into the instruction-side and the data-side slot at the requested index. Every other slot keeps its contents.
- R5: A request is refused when the size is not a power of two, is below 128 KB, or is above 256 MB. A refused request raises `err` for exactly the next cycle, keeps `done` low, and writes no slot.
- R6: An accepted request raises `done` for exactly the next cycle. `done` and `err` are never high together.
- R7: A read with `rd_en` high, index `rd_idx` and side `rd_side` (0 selects the data side, 1 the instruction side) presents that slot's upper and lower words on `rd_upper` and `rd_lower` with `rd_valid` high in the next cycle.
- R8: A read and an accepted write to the same slot in the same cycle return the contents from before the write. The new words appear on the next read.
- R9: While `rst` is high, and in the cycle after it, `err`, `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_idx | input | 2 | Slot index to write |
| req_vbase | input | 32 | Virtual base address |
| req_pbase | input | 32 | Physical base address |
| req_size | input | 32 | Region size in bytes |
| req_sv | input | 1 | Supervisor-valid bit |
| req_uv | input | 1 | User-valid bit |
| req_prot | input | 2 | Protection bits |
| done | output | 1 | Request accepted and written |
| err | output | 1 | Request refused |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 2 | Slot index to read |
| rd_side | input | 1 | 0 data side, 1 instruction side |
| rd_valid | output | 1 | Read data valid |
| rd_upper | output | 32 | Upper word of the read slot |
| rd_lower | output | 32 | Lower word of the read slot |

## Verification
A write request and a readback can hit the same slot in the same cycle. This is the case where the storage ordering matters. The bench drives `req_valid` and `rd_en` on the same clock edge with equal indices, after it has stored known words in that slot. It expects the previous words on the read port and then the new words on a follow-up read of both sides. Refused requests are judged the same way: the bench reads the slot they named and expects the earlier contents.

// File: rtl/blk_xlat_pkg.sv
package blk_xlat_pkg;
  // Bank selector used on the readback port
  typedef enum logic {
    SIDE_DATA  = 1'b0,
    SIDE_INSTR = 1'b1
  } xlat_side_e;

  localparam int XLAT_ADDR_W   = 32;
  localparam int XLAT_MIN_LOG2 = 17;  // smallest region: 128 KB
  localparam int XLAT_LEN_W    = 11;  // length mask width, largest region 256 MB
  localparam int XLAT_PROT_W   = 2;
  localparam int XLAT_SLOTS    = 4;
  localparam int XLAT_LEN_LSB  = 2;   // bit position of the length mask in the upper word
endpackage

// File: rtl/blk_xlat_size_decode.sv
module blk_xlat_size_decode #(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 17,
  parameter int LEN_W    = 11
) (
  input  logic [ADDR_W-1:0] size,
  output logic              size_ok,
  output logic [LEN_W-1:0]  len_mask,
  output logic [ADDR_W-1:0] keep_mask
);
  localparam int LG_W = $clog2(ADDR_W);
  localparam logic [LG_W-1:0] LG_MIN = LG_W'(MIN_LOG2);
  localparam logic [LG_W-1:0] LG_MAX = LG_W'(MIN_LOG2 + LEN_W);

  logic            is_pow2;
  logic [LG_W-1:0] lg;
  logic [LG_W-1:0] steps;

  // Exactly one bit set means a power of two
  always_comb begin
    is_pow2 = (size != '0) && ((size & (size - ADDR_W'(1))) == '0);
  end

  // Position of the highest set bit
  always_comb begin
    lg = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (size[i]) lg = LG_W'(i);
    end
  end

  always_comb begin
    size_ok = is_pow2 && (lg >= LG_MIN) && (lg <= LG_MAX);
    steps   = lg - LG_MIN;
  end

  // Thermometer mask: one set bit per doubling above the minimum
  generate
    for (genvar j = 0; j < LEN_W; j++) begin : g_len
      assign len_mask[j] = size_ok && (LG_W'(j) < steps);
    end
  endgenerate

  // Clears the base bits that fall inside the region
  always_comb begin
    keep_mask = ~(size - ADDR_W'(1));
  end
endmodule

// File: rtl/blk_xlat_word_pack.sv
module blk_xlat_word_pack #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 11,
  parameter int PROT_W  = 2,
  parameter int LEN_LSB = 2
) (
  input  logic [ADDR_W-1:0] vbase,
  input  logic [ADDR_W-1:0] pbase,
  input  logic [ADDR_W-1:0] keep_mask,
  input  logic [LEN_W-1:0]  len_mask,
  input  logic              sv,
  input  logic              uv,
  input  logic [PROT_W-1:0] prot,
  output logic [ADDR_W-1:0] upper,
  output logic [ADDR_W-1:0] lower
);
  logic [ADDR_W-1:0] len_field;
  logic [ADDR_W-1:0] flag_field;
  logic [ADDR_W-1:0] prot_field;

  always_comb begin
    len_field  = ADDR_W'(len_mask) << LEN_LSB;
    flag_field = ADDR_W'({sv, uv});
    prot_field = ADDR_W'(prot);
    upper = (vbase & keep_mask) | len_field | flag_field;
    // cache-mode bits stay zero
    lower = (pbase & keep_mask) | prot_field;
  end
endmodule

// File: rtl/blk_xlat_bank.sv
module blk_xlat_bank #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Read-first simple dual-port memory, no reset, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/blk_xlat_encoder.sv
module blk_xlat_encoder
  import blk_xlat_pkg::*;
#(
  parameter int ADDR_W   = XLAT_ADDR_W,
  parameter int MIN_LOG2 = XLAT_MIN_LOG2,
  parameter int LEN_W    = XLAT_LEN_W,
  parameter int PROT_W   = XLAT_PROT_W,
  parameter int SLOTS    = XLAT_SLOTS,
  localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_vbase,
  input  logic [ADDR_W-1:0] req_pbase,
  input  logic [ADDR_W-1:0] req_size,
  input  logic              req_sv,
  input  logic              req_uv,
  input  logic [PROT_W-1:0] req_prot,
  output logic              done,
  output logic              err,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_side,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_upper,
  output logic [ADDR_W-1:0] rd_lower
);
  localparam int PAIR_W = 2 * ADDR_W;
  localparam int SIDES  = 2;

  logic              size_ok;
  logic [LEN_W-1:0]  len_mask;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] up_word;
  logic [ADDR_W-1:0] lo_word;
  logic              wr_go;
  logic              done_q;
  logic              err_q;
  logic              rvalid_q;
  xlat_side_e        rside_q;
  logic [PAIR_W-1:0] bank_rd [SIDES];
  logic [PAIR_W-1:0] sel_pair;

  blk_xlat_size_decode #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .LEN_W(LEN_W)
  ) u_dec (
    .size(req_size), .size_ok(size_ok), .len_mask(len_mask), .keep_mask(keep_mask)
  );

  blk_xlat_word_pack #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PROT_W(PROT_W), .LEN_LSB(XLAT_LEN_LSB)
  ) u_pack (
    .vbase(req_vbase), .pbase(req_pbase), .keep_mask(keep_mask), .len_mask(len_mask),
    .sv(req_sv), .uv(req_uv), .prot(req_prot), .upper(up_word), .lower(lo_word)
  );

  assign wr_go = req_valid && size_ok;

  // One bank per side, both written with the same pair
  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      blk_xlat_bank #(.DEPTH(SLOTS), .WIDTH(PAIR_W)) u_bank (
        .clk(clk), .we(wr_go), .waddr(req_idx), .wdata({up_word, lo_word}),
        .re(rd_en), .raddr(rd_idx), .rdata(bank_rd[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rside_q  <= SIDE_DATA;
    end else begin
      done_q   <= wr_go;
      err_q    <= req_valid && !size_ok;
      rvalid_q <= rd_en;
      if (rd_en) rside_q <= xlat_side_e'(rd_side);
    end
  end

  always_comb begin
    sel_pair = (rside_q == SIDE_INSTR) ? bank_rd[1] : bank_rd[0];
  end

  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = rvalid_q;
  assign rd_upper = sel_pair[PAIR_W-1:ADDR_W];
  assign rd_lower = sel_pair[ADDR_W-1:0];
endmodule

// File: rtl/blk_xlat_encoder_chk.sv
module blk_xlat_encoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 17,
  parameter int LEN_W    = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_size,
  input logic              done,
  input logic              err,
  input logic              rd_en,
  input logic              rd_valid
);
  localparam logic [ADDR_W-1:0] SZ_MIN = ADDR_W'(1) << MIN_LOG2;
  localparam logic [ADDR_W-1:0] SZ_MAX = ADDR_W'(1) << (MIN_LOG2 + LEN_W);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst) !(done && err));

  p_not_pow2_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $countones(req_size) != 1) |=> (err && !done));

  p_too_small_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size < SZ_MIN) |=> (err && !done));

  p_too_big_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size > SZ_MAX) |=> (err && !done));

  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $countones(req_size) == 1 && req_size >= SZ_MIN && req_size <= SZ_MAX)
      |=> (done && !err));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid));

  p_rd_lat_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_cause_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!done && !err && !rd_valid));
endmodule

bind blk_xlat_encoder blk_xlat_encoder_chk #(
  .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
  .done(done), .err(err), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/sim_blk_xlat_encoder.sv
module sim_blk_xlat_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_idx = '0;
  logic [31:0] req_vbase = '0;
  logic [31:0] req_pbase = '0;
  logic [31:0] req_size = '0;
  logic        req_sv = 1'b0;
  logic        req_uv = 1'b0;
  logic [1:0]  req_prot = '0;
  logic        done, err;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic        rd_side = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_upper, rd_lower;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_up [4];
  logic [31:0] exp_lo [4];

  always #10 clk = ~clk;  // 50 MHz

  blk_xlat_encoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_vbase(req_vbase), .req_pbase(req_pbase), .req_size(req_size),
    .req_sv(req_sv), .req_uv(req_uv), .req_prot(req_prot),
    .done(done), .err(err), .rd_en(rd_en), .rd_idx(rd_idx), .rd_side(rd_side),
    .rd_valid(rd_valid), .rd_upper(rd_upper), .rd_lower(rd_lower)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Expected words, computed from the requirement text
  function automatic logic [31:0] f_up(logic [31:0] v, logic [31:0] sz, logic sv, logic uv);
    int k = 0;
    logic [31:0] m = '0;
    for (int t = 17; t < 32; t++) if (sz == (32'd1 << t)) k = t - 17;
    for (int b = 0; b < k; b++) m[b] = 1'b1;
    return (v & ~(sz - 32'd1)) | (m << 2) | {30'd0, sv, uv};
  endfunction

  function automatic logic [31:0] f_lo(logic [31:0] p, logic [31:0] sz, logic [1:0] pr);
    return (p & ~(sz - 32'd1)) | {30'd0, pr};
  endfunction

  task automatic drive_req(input logic [1:0] idx, input logic [31:0] v, input logic [31:0] p,
                           input logic [31:0] sz, input logic sv, input logic uv,
                           input logic [1:0] pr);
    req_valid = 1'b1; req_idx = idx; req_vbase = v; req_pbase = p;
    req_size = sz; req_sv = sv; req_uv = uv; req_prot = pr;
  endtask

  // Accepted write; updates the expected slot contents
  task automatic do_write(input string tag, input logic [1:0] idx, input logic [31:0] v,
                          input logic [31:0] p, input logic [31:0] sz, input logic sv,
                          input logic uv, input logic [1:0] pr);
    @(negedge clk);
    drive_req(idx, v, p, sz, sv, uv, pr);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " done R6"}, {31'd0, done}, 32'd1);
    chk({tag, " err R6"}, {31'd0, err}, 32'd0);
    exp_up[idx] = f_up(v, sz, sv, uv);
    exp_lo[idx] = f_lo(p, sz, pr);
  endtask

  // Refused write: error pulse, no done
  task automatic do_bad(input string tag, input logic [1:0] idx, input logic [31:0] sz);
    @(negedge clk);
    drive_req(idx, 32'hFFFF_FFFF, 32'hFFFF_FFFF, sz, 1'b1, 1'b1, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " err R5"}, {31'd0, err}, 32'd1);
    chk({tag, " done R5"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    chk({tag, " err one cycle R5"}, {31'd0, err}, 32'd0);
  endtask

  task automatic do_read(input string tag, input logic [1:0] idx, input logic side,
                         input logic [31:0] eu, input logic [31:0] el);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx; rd_side = side;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rd_valid R7"}, {31'd0, rd_valid}, 32'd1);
    chk({tag, " upper"}, rd_upper, eu);
    chk({tag, " lower"}, rd_lower, el);
  endtask

  task automatic read_both(input string tag, input logic [1:0] idx);
    do_read({tag, " data R4"}, idx, 1'b0, exp_up[idx], exp_lo[idx]);
    do_read({tag, " instr R4"}, idx, 1'b1, exp_up[idx], exp_lo[idx]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset done R9", {31'd0, done}, 32'd0);
    chk("reset err R9", {31'd0, err}, 32'd0);
    chk("reset rd_valid R9", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_lengths;
    do_write("128K R1", 2'd0, 32'h1234_5678, 32'h0ABC_DEF0, 32'h0002_0000, 1'b1, 1'b0, 2'b10);
    chk("128K mask R1", exp_up[0] & 32'h1FFC, 32'h0);
    do_write("256K R1", 2'd1, 32'h8765_4321, 32'h1357_9BDF, 32'h0004_0000, 1'b0, 1'b1, 2'b01);
    chk("256K mask R1", exp_up[1] & 32'h1FFC, 32'h4);
    do_write("512K R2", 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0008_0000, 1'b1, 1'b1, 2'b11);
    chk("512K upper R2", exp_up[2], 32'hFFF8_000F);
    chk("512K lower R3", exp_lo[2], 32'hFFF8_0003);
    do_write("256M R1", 2'd3, 32'hF123_4567, 32'h2FED_CBA9, 32'h1000_0000, 1'b0, 1'b0, 2'b00);
    chk("256M upper R1", exp_up[3], 32'hF000_1FFC);
    read_both("slot0 R1", 2'd0);
    read_both("slot1 R2", 2'd1);
    read_both("slot2 R3", 2'd2);
    read_both("slot3 R1", 2'd3);
  endtask

  task automatic t_refused;
    do_bad("non-pow2", 2'd1, 32'h0006_0000);
    do_bad("64K", 2'd2, 32'h0001_0000);
    do_bad("512M", 2'd3, 32'h2000_0000);
    do_bad("zero", 2'd0, 32'h0);
    read_both("after refusal R5", 2'd1);
    read_both("after refusal R5", 2'd2);
    read_both("after refusal R5", 2'd3);
    read_both("after refusal R5", 2'd0);
  endtask

  task automatic t_isolation;
    do_write("slot2 rewrite R4", 2'd2, 32'h4000_0000, 32'h0800_0000, 32'h0040_0000, 1'b1, 1'b0, 2'b10);
    read_both("neighbour1 R4", 2'd1);
    read_both("neighbour3 R4", 2'd3);
    read_both("rewritten R4", 2'd2);
  endtask

  task automatic t_collision;
    logic [31:0] old_u, old_l;
    old_u = exp_up[0];
    old_l = exp_lo[0];
    @(negedge clk);
    drive_req(2'd0, 32'hC000_0000, 32'h0020_0000, 32'h0010_0000, 1'b1, 1'b1, 2'b01);
    rd_en = 1'b1; rd_idx = 2'd0; rd_side = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rd_en = 1'b0;
    chk("collide done R8", {31'd0, done}, 32'd1);
    chk("collide old upper R8", rd_upper, old_u);
    chk("collide old lower R8", rd_lower, old_l);
    exp_up[0] = f_up(32'hC000_0000, 32'h0010_0000, 1'b1, 1'b1);
    exp_lo[0] = f_lo(32'h0020_0000, 32'h0010_0000, 2'b01);
    read_both("collide new R8", 2'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_lengths();
    t_refused();
    t_isolation();
    t_collision();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule